// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block is the timing generator for a full-frame image sensor that has a two-phase vertical shift register and a two-phase horizontal shift register. A start request begins an exposure interval, during which every register clock is held still. The sequencer then shifts the frame out one line at a time. For each line it clocks the vertical register through a four-step, non-overlapping sequence, which hands a row to the horizontal register. It then toggles the horizontal phases once for every position in that row. After each charge packet reaches the sense node, it raises a sample strobe and then a reset-gate pulse.

Every sample strobe comes with a region tag and two position counters. The position counter counts the horizontal register position from 0, and the line counter counts the frame line from 0. Each line is laid out as 10 dummy positions, 4 dark positions, the programmable active columns, 12 dark positions and 2 dummy positions. This gives the active-column count plus 28 pixels per line. Each frame is made of 4 dark lines, the programmable active rows, and 4 more dark lines. A one-clock frame-done pulse follows the last line.

The half-period of the horizontal clocks, the length of each vertical phase, the delay from the falling edge of H2 to the sample strobe, and the width of the reset pulse are all parameters counted in system clocks. The design requires SAMP_DLY + RST_W < H_HALF.

Top module: `ccd_seq`

## Requirements
- R1: While idle and after reset, V1=0, V2=0, H1=1, H2=0, reset gate=0, sample=0, busy=0 and frame_done=0.
- R2: A start accepted on a clock edge begins an exposure of exp_cycles+1 clocks. During the exposure busy=1 and all clocks hold their idle levels.
- R3: Each line begins with a vertical transfer of four phases of V_PH clocks each, with (V1,V2) equal to (1,0), (1,1), (0,1) and (0,0) in that order.
- R4: H1 is high and H2 is low for the whole vertical transfer, including the clock in which V2 falls. No horizontal clocking takes place during the transfer.
- R5: H2 is the complement of H1 on every clock.
- R6: After its vertical transfer, each line has act_cols+28 pixel periods of 2*H_HALF clocks each. In each period H2 is high for the first H_HALF clocks and low for the rest, so there is one H2 falling edge per pixel.
- R7: The sample strobe is high for exactly one clock, SAMP_DLY clocks after each H2 falling edge, and at no other time.
- R8: The reset gate is high for RST_W clocks, starting on the clock after each sample strobe, and is low again before the next H2 falling edge.
- R9: With a sample, col_idx gives the pixel position p (0 to act_cols+27) and tag gives the region, encoded as 0 for dummy, 1 for dark and 2 for active. Positions p<10 and p>=act_cols+26 are dummy. Positions 10 to 13 and act_cols+14 to act_cols+25 are dark.
- R10: line_idx runs from 0 to act_rows+7. Lines below 4 and lines at act_rows+4 and above are dark lines, in which the non-dummy positions carry the dark tag.
- R11: A start request made while busy is ignored and leaves the timing of the frame in progress unchanged.
- R12: frame_done is a one-clock pulse in the clock after the last pixel period of line act_rows+7. The block is idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start request, accepted only while idle |
| exp_cycles | input | EW | Exposure length minus one, in clocks |
| act_cols | input | CW | Active column count |
| act_rows | input | CW | Active row count |
| v1 | output | 1 | Vertical phase 1 clock |
| v2 | output | 1 | Vertical phase 2 clock |
| h1 | output | 1 | Horizontal phase 1 clock |
| h2 | output | 1 | Horizontal phase 2 clock |
| rg | output | 1 | Reset-gate pulse |
| sample | output | 1 | Sample strobe |
| tag | output | 2 | Region tag: 0 dummy, 1 dark, 2 active |
| col_idx | output | CW+1 | Pixel position in the line |
| line_idx | output | CW+1 | Line number in the frame |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-clock end-of-frame pulse |

## Verification
The outputs are compared on every clock against the expected waveform, which is derived only from the elapsed time since the start. A wrong phase counter, pixel counter or line counter therefore appears as a clock-level mismatch in the first clock where it diverges, and all later edges of that frame are shifted. A wrong region boundary only appears at the sample strobe of the position where it occurs, as a wrong tag. A wrong line-end condition appears either as a missing or extra vertical transfer, or as a frame_done pulse that comes early or late.

// File: rtl/ccd_seq.sv
module ccd_seq #(
  parameter int CW       = 12,
  parameter int EW       = 24,
  parameter int H_HALF   = 3,
  parameter int SAMP_DLY = 1,
  parameter int RST_W    = 1,
  parameter int V_PH     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [EW-1:0] exp_cycles,
  input  logic [CW-1:0] act_cols,
  input  logic [CW-1:0] act_rows,
  output logic          v1,
  output logic          v2,
  output logic          h1,
  output logic          h2,
  output logic          rg,
  output logic          sample,
  output logic [1:0]    tag,
  output logic [CW:0]   col_idx,
  output logic [CW:0]   line_idx,
  output logic          busy,
  output logic          frame_done
);
  localparam int PER  = 2 * H_HALF;
  localparam int PW   = (PER > 2) ? $clog2(PER) : 1;
  localparam int S_AT = H_HALF + SAMP_DLY;
  localparam logic [1:0] TG_DUM = 2'd0, TG_DRK = 2'd1, TG_ACT = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_EXPO, S_VX, S_HR, S_DONE} st_t;
  st_t st;

  logic [EW-1:0] tmr;
  logic [1:0]    vph;
  logic [PW-1:0] ph;
  logic [CW:0]   pix, lidx;

  wire [CW:0] cols_w    = {1'b0, act_cols};
  wire [CW:0] rows_w    = {1'b0, act_rows};
  wire [CW:0] last_pix  = cols_w + (CW+1)'(27);
  wire [CW:0] last_line = rows_w + (CW+1)'(7);
  wire        tmr_end   = (tmr == '0);
  wire        ph_end    = (ph == PW'(PER-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tmr  <= '0;
      vph  <= '0;
      ph   <= '0;
      pix  <= '0;
      lidx <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st   <= S_EXPO;
          tmr  <= exp_cycles;
          lidx <= '0;
        end
        S_EXPO: if (tmr_end) begin
          st  <= S_VX;
          tmr <= EW'(V_PH-1);
          vph <= '0;
        end else tmr <= tmr - 1'b1;
        S_VX: if (tmr_end) begin
          tmr <= EW'(V_PH-1);
          if (vph == 2'd3) begin
            st  <= S_HR;
            ph  <= '0;
            pix <= '0;
          end else vph <= vph + 1'b1;
        end else tmr <= tmr - 1'b1;
        S_HR: if (ph_end) begin
          ph <= '0;
          if (pix == last_pix) begin
            if (lidx == last_line) st <= S_DONE;
            else begin
              lidx <= lidx + 1'b1;
              st   <= S_VX;
              vph  <= '0;
              tmr  <= EW'(V_PH-1);
            end
          end else pix <= pix + 1'b1;
        end else ph <= ph + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire in_hr = (st == S_HR);
  wire in_vx = (st == S_VX);

  assign v1         = in_vx && (vph <= 2'd1);
  assign v2         = in_vx && (vph == 2'd1 || vph == 2'd2);
  assign h2         = in_hr && (ph < PW'(H_HALF));
  assign h1         = !in_hr || (ph >= PW'(H_HALF));
  assign sample     = in_hr && (ph == PW'(S_AT));
  assign rg         = in_hr && (ph > PW'(S_AT)) && (ph <= PW'(S_AT + RST_W));
  assign busy       = (st != S_IDLE);
  assign frame_done = (st == S_DONE);
  assign col_idx    = pix;
  assign line_idx   = lidx;

  wire dark_line = (lidx < (CW+1)'(4)) || (lidx >= rows_w + (CW+1)'(4));

  always_comb begin
    if (pix < (CW+1)'(10) || pix >= cols_w + (CW+1)'(26)) tag = TG_DUM;
    else if (pix < (CW+1)'(14) || pix >= cols_w + (CW+1)'(14)) tag = TG_DRK;
    else tag = dark_line ? TG_DRK : TG_ACT;
  end

  // R2
  expo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXPO) |-> (!v1 && !v2 && h1 && !rg && !sample));
  // R3
  v_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v2) |-> v1);
  // R4
  v2_fall_h1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v2) |-> (h1 && !h2));
  // R5
  h_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h2 != h1);
  // R7
  sample_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (h1 && !v1 && !v2));
  // R8
  rg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rg |-> (!sample && !h2));
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);
endmodule

// File: tb/ccd_seq_tb.sv
module ccd_seq_tb_top;
  localparam int CW = 12, EW = 24, HH = 3, SD = 1, RW = 1, VP = 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [EW-1:0] exp_cycles = '0;
  logic [CW-1:0] act_cols = '0, act_rows = '0;
  logic v1, v2, h1, h2, rg, sample, busy, frame_done;
  logic [1:0] tag;
  logic [CW:0] col_idx, line_idx;

  always #5 clk = ~clk;

  ccd_seq #(.CW(CW), .EW(EW), .H_HALF(HH), .SAMP_DLY(SD), .RST_W(RW), .V_PH(VP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_cycles(exp_cycles),
    .act_cols(act_cols), .act_rows(act_rows), .v1(v1), .v2(v2), .h1(h1), .h2(h2),
    .rg(rg), .sample(sample), .tag(tag), .col_idx(col_idx), .line_idx(line_idx),
    .busy(busy), .frame_done(frame_done));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: elapsed clocks since start acceptance
  int t = -1, m_exp, m_cols, m_rows;
  int n_samp, n_dum, n_drk, n_act, n_done;

  function automatic int line_len();
    return 4*VP + (m_cols + 28) * 2*HH;
  endfunction
  function automatic int total_t();
    return m_exp + 1 + (m_rows + 8) * line_len();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) t = -1;
    else if (t >= 0) begin
      if (t == total_t()) t = -1; else t++;
    end else if (start) begin
      t = 0; m_exp = int'(exp_cycles); m_cols = int'(act_cols); m_rows = int'(act_rows);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_v1, e_v2, e_h1, e_h2, e_rg, e_s, e_busy, e_done, e_tag, e_line, e_pix;
      string ph;
      e_v1 = 0; e_v2 = 0; e_h1 = 1; e_h2 = 0; e_rg = 0; e_s = 0;
      e_busy = (t >= 0); e_done = 0; e_tag = 0; e_line = 0; e_pix = 0; ph = "R1";
      if (t >= 0 && t <= m_exp) ph = "R2";
      else if (t > m_exp) begin
        int t2, r;
        t2 = t - m_exp - 1;
        if (t2 >= (m_rows + 8) * line_len()) begin e_done = 1; ph = "R12"; end
        else begin
          e_line = t2 / line_len();
          r = t2 % line_len();
          if (r < 4*VP) begin
            int q;
            q = r / VP;
            e_v1 = (q < 2); e_v2 = (q == 1 || q == 2); ph = "R3";
          end else begin
            int p, o;
            p = r - 4*VP; e_pix = p / (2*HH); o = p % (2*HH);
            e_h2 = (o < HH); e_h1 = !e_h2;
            e_s = (o == HH + SD);
            e_rg = (o > HH + SD) && (o <= HH + SD + RW);
            ph = "R6";
            if (e_pix < 10 || e_pix >= m_cols + 26) e_tag = 0;
            else if (e_pix < 14 || e_pix >= m_cols + 14) e_tag = 1;
            else if (e_line < 4 || e_line >= m_rows + 4) e_tag = 1;
            else e_tag = 2;
          end
        end
      end
      chk(v1 == e_v1[0] && v2 == e_v2[0], ph, {v1, v2}, {e_v1[0], e_v2[0]});
      chk(h1 == e_h1[0], (ph == "R3") ? "R4" : ph, h1, e_h1);
      chk(h2 == ~h1, "R5", h2, !h1);
      chk(sample == e_s[0], "R7", sample, e_s);
      chk(rg == e_rg[0], "R8", rg, e_rg);
      chk(busy == e_busy[0] && frame_done == e_done[0], "R12", {busy, frame_done}, {e_busy[0], e_done[0]});
      if (sample && e_s) begin
        chk(int'(col_idx) == e_pix && int'(tag) == e_tag, "R9", int'(tag)*1000 + int'(col_idx), e_tag*1000 + e_pix);
        chk(int'(line_idx) == e_line, "R10", line_idx, e_line);
        n_samp++;
        if (tag == 2'd0) n_dum++; else if (tag == 2'd1) n_drk++; else n_act++;
      end
      if (frame_done) n_done++;
    end
  end

  task automatic run_frame(input int ex, input int cols, input int rows, input bit poke);
    int exp_s;
    n_samp = 0; n_dum = 0; n_drk = 0; n_act = 0; n_done = 0;
    @(negedge clk);
    exp_cycles = EW'(ex); act_cols = CW'(cols); act_rows = CW'(rows); start = 1;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1;                        // R11: ignored while busy
      @(negedge clk); start = 0;
    end
    while (!frame_done) @(negedge clk);
    repeat (3) @(negedge clk);
    exp_s = (rows + 8) * (cols + 28);
    chk(n_samp == exp_s, "R6", n_samp, exp_s);
    chk(n_dum == (rows + 8) * 12, "R9", n_dum, (rows + 8) * 12);
    chk(n_act == rows * cols, "R10", n_act, rows * cols);
    chk(n_drk == exp_s - (rows + 8) * 12 - rows * cols, "R10", n_drk, exp_s - (rows + 8) * 12 - rows * cols);
    chk(n_done == 1, "R11", n_done, 1);
    chk(!busy, "R12", busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!v1 && !v2 && h1 && !h2 && !rg && !sample && !busy && !frame_done, "R1",
        {v1, v2, h1, h2, rg, sample, busy, frame_done}, 8'b00100000);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run_frame(5, 3, 2, 1);
    run_frame(0, 1, 1, 0);
    run_frame(2, 4, 0, 1);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule